// File: doc/BRIEF.md
# Programmable audio clock divider

This block makes the timing for an audio serial port from one of two reference clocks, all inside one fast system clock domain. Each reference arrives as a one-cycle tick on a system-clock input. A source-select bit picks either the internal PLL tick stream, which is first halved, or the external reference tick stream, which is used as it is. A 7-bit programmable divider turns the selected reference into a bit clock. A fixed frame divider then turns the bit clock into a left/right frame clock at the sample rate.

A mode bit chooses whether the bit clock runs at 128 or at 64 times the sample rate. The frame divider follows that choice, so the frame clock always runs at the sample rate. With a 73.728 MHz PLL the divisors 36, 24, 18, 12, 9 and 6 give 8, 12, 16, 24, 32 and 48 kHz. With an 11.2896 MHz external reference the divisors 8, 4 and 2 give 11.025, 22.05 and 44.1 kHz. Every output comes as a registered single-cycle pulse and as a toggled level clock. Changes to the divisor, mode and source take effect only at a frame boundary, so no period is ever cut short.

Top module: `audclk_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bclk`, `lrclk`, `bclk_en` and `frame_en` are all low.
- R2: With `cfg_src_ext`=1, `bclk_en` pulses once every D external ticks, where D is the active divisor.
- R3: With `cfg_src_ext`=0, `bclk_en` pulses once every 2×D PLL ticks, because the PLL path is halved before the divider.
- R4: In each bit period `bclk` is low for ceil(D/2) reference ticks and then high for floor(D/2) ticks. Its falling edge is the `bclk_en` cycle, so an odd D keeps the right period and the two phases differ by one tick.
- R5: A divisor of 0 or 1 divides by 1. `bclk_en` then pulses on every reference tick and `bclk` stays low.
- R6: With `cfg_fs64`=0 a frame lasts 128 bit periods. `lrclk` is low for the first 64 of them and high for the last 64.
- R7: With `cfg_fs64`=1 a frame lasts 64 bit periods. `lrclk` is low for the first 32 and high for the last 32.
- R8: `lrclk` changes level only in a cycle where `bclk_en` is high, that is, on a bit-clock falling edge.
- R9: A change of `cfg_div`, `cfg_fs64` or `cfg_src_ext` during a frame has no effect until the next `frame_en` pulse. The new values govern the frame that starts there. During reset, the inputs are loaded directly.
- R10: `frame_en` pulses once per frame, in the cycle where `lrclk` falls from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also loads the configuration |
| pll_tick | input | 1 | One-cycle tick per PLL reference period |
| ext_tick | input | 1 | One-cycle tick per external reference period |
| cfg_src_ext | input | 1 | 1 selects the external reference, 0 selects the halved PLL reference |
| cfg_div | input | 7 | Bit-clock divisor; 0 and 1 both mean divide by 1 |
| cfg_fs64 | input | 1 | 1 gives a 64×Fs bit clock and 64-bit frames, 0 gives 128×Fs and 128-bit frames |
| bclk_en | output | 1 | One-cycle pulse at each bit-clock falling edge |
| bclk | output | 1 | Toggled bit clock |
| lrclk | output | 1 | Frame clock: low for the left half, high for the right half |
| frame_en | output | 1 | One-cycle pulse at each frame start |

## Verification
The assertions assume that the reference ticks are single-cycle pulses and that `rst` is held for at least one clock before any property is checked. They make no assumption about tick spacing or about when the configuration changes. The stimulus produces ticks from a bench counter at a fixed gap for each test, so the expected periods are exact multiples of that gap. It changes the configuration in the middle of a frame only in the frame-boundary test. Every other test applies its configuration under reset, and it measures intervals only after the first partial period has passed.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Divisor values below 2 collapse to divide-by-one.
  function automatic int aud_eff_div(input int d);
    return (d < 2) ? 1 : d;
  endfunction

  // Reference ticks spent low in one bit period (ceil of half).
  function automatic int aud_low_ticks(input int d);
    int e;
    e = aud_eff_div(d);
    return e - (e / 2);
  endfunction

  // Bit periods in one frame for the selected ratio.
  function automatic int aud_frame_bits(input bit fs64, input int bits_hi, input int bits_lo);
    return fs64 ? bits_lo : bits_hi;
  endfunction

endpackage

// File: rtl/audclk_refsel.sv
module audclk_refsel (
  input  logic clk,
  input  logic rst,
  input  logic pll_tick,
  input  logic ext_tick,
  input  logic use_ext,
  output logic ref_tick
);
  logic half_q;

  // Halver phase advances on every PLL tick whichever source is active.
  always_ff @(posedge clk) begin
    if (rst)           half_q <= 1'b0;
    else if (pll_tick) half_q <= ~half_q;
  end

  always_comb begin
    if (use_ext) ref_tick = ext_tick;
    else         ref_tick = pll_tick & half_q;
  end

  // R3: a halved PLL tick leaves the halver on its even phase
  a_r3_halved_phase: assert property (@(posedge clk) disable iff (rst)
    (!use_ext && ref_tick) |=> !half_q);

endmodule

// File: rtl/audclk_bitdiv.sv
module audclk_bitdiv
  import audclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             fall_evt,
  output logic             bclk_en_q,
  output logic             bclk_q
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_idx;
  logic [DIV_W-1:0] rise_idx;
  logic             div_is_one;
  logic             rise_evt;

  always_comb begin
    last_idx   = DIV_W'(aud_eff_div(int'(div)) - 1);
    rise_idx   = DIV_W'(aud_low_ticks(int'(div)) - 1);
    div_is_one = (last_idx == '0);
    fall_evt   = ref_tick && (cnt_q == last_idx);
    rise_evt   = ref_tick && (cnt_q == rise_idx) && !div_is_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      bclk_q    <= 1'b0;
      bclk_en_q <= 1'b0;
    end else begin
      bclk_en_q <= fall_evt;
      if (ref_tick) begin
        if (cnt_q == last_idx) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      if (fall_evt)      bclk_q <= 1'b0;
      else if (rise_evt) bclk_q <= 1'b1;
    end
  end

  // R2: the tick counter never passes the programmed limit
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx);
  // R5: divide-by-one leaves no room for a high phase
  a_r5_div1_low: assert property (@(posedge clk) disable iff (rst)
    (div_is_one && !bclk_q) |=> !bclk_q);
  // R4: a falling-edge pulse always leaves the bit clock low
  a_r4_en_at_low: assert property (@(posedge clk) disable iff (rst)
    bclk_en_q |-> !bclk_q);

endmodule

// File: rtl/audclk_framediv.sv
module audclk_framediv
  import audclk_pkg::*;
#(
  parameter int BITS_HI = 128,
  parameter int BITS_LO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_evt,
  input  logic fs64,
  output logic wrap_evt,
  output logic lrclk_q,
  output logic frame_en_q
);
  localparam int FCW = $clog2(BITS_HI);

  logic [FCW-1:0] cnt_q;
  logic [FCW-1:0] last_idx;
  logic [FCW-1:0] mid_idx;
  logic           mid_evt;

  always_comb begin
    last_idx = FCW'(aud_frame_bits(fs64, BITS_HI, BITS_LO) - 1);
    mid_idx  = FCW'(aud_frame_bits(fs64, BITS_HI, BITS_LO) / 2 - 1);
    wrap_evt = bit_evt && (cnt_q == last_idx);
    mid_evt  = bit_evt && (cnt_q == mid_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      lrclk_q    <= 1'b0;
      frame_en_q <= 1'b0;
    end else begin
      frame_en_q <= wrap_evt;
      if (bit_evt) begin
        if (cnt_q == last_idx) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      if (wrap_evt)     lrclk_q <= 1'b0;
      else if (mid_evt) lrclk_q <= 1'b1;
    end
  end

  // R10: a frame pulse marks the fall of the frame clock
  a_r10_frame_on_fall: assert property (@(posedge clk) disable iff (rst)
    frame_en_q |-> $fell(lrclk_q));
  // R6: the bit counter stays within the frame length
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx);

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int BITS_HI = 128,
  parameter int BITS_LO = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_tick,
  input  logic             ext_tick,
  input  logic             cfg_src_ext,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_fs64,
  output logic             bclk_en,
  output logic             bclk,
  output logic             lrclk,
  output logic             frame_en
);
  // Active configuration, reloaded only at reset or a frame wrap.
  logic [DIV_W-1:0] act_div;
  logic             act_fs64;
  logic             act_src_ext;

  // Named internal events, shared by the stages and the assertions.
  logic ref_tick;
  logic bit_fall_evt;
  logic frame_wrap_evt;

  always_ff @(posedge clk) begin
    if (rst || frame_wrap_evt) begin
      act_div     <= cfg_div;
      act_fs64    <= cfg_fs64;
      act_src_ext <= cfg_src_ext;
    end
  end

  audclk_refsel u_refsel (
    .clk      (clk),
    .rst      (rst),
    .pll_tick (pll_tick),
    .ext_tick (ext_tick),
    .use_ext  (act_src_ext),
    .ref_tick (ref_tick)
  );

  audclk_bitdiv #(.DIV_W(DIV_W)) u_bitdiv (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .div       (act_div),
    .fall_evt  (bit_fall_evt),
    .bclk_en_q (bclk_en),
    .bclk_q    (bclk)
  );

  audclk_framediv #(.BITS_HI(BITS_HI), .BITS_LO(BITS_LO)) u_framediv (
    .clk        (clk),
    .rst        (rst),
    .bit_evt    (bit_fall_evt),
    .fs64       (act_fs64),
    .wrap_evt   (frame_wrap_evt),
    .lrclk_q    (lrclk),
    .frame_en_q (frame_en)
  );

  // R9: active settings hold between frame boundaries
  a_r9_div_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap_evt |=> $stable(act_div));
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap_evt |=> ($stable(act_fs64) && $stable(act_src_ext)));
  // R8: the frame clock moves only on a bit-clock falling edge
  a_r8_lr_on_bclk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> bclk_en);
  // R10: each frame pulse is also a bit pulse
  a_r10_frame_in_bit: assert property (@(posedge clk) disable iff (rst)
    frame_en |-> bclk_en);

endmodule

// File: tb/tb_audclk_gen.sv
module tb_audclk_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pll_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       cfg_src_ext = 1'b1;
  logic [6:0] cfg_div = 7'd2;
  logic       cfg_fs64 = 1'b0;
  logic       bclk_en, bclk, lrclk, frame_en;

  int  total = 0;
  int  bad = 0;
  int  pll_gap = 1;
  int  ext_gap = 1;
  longint cyc = 0;
  bit  finished = 0;

  audclk_gen dut (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .ext_tick(ext_tick),
    .cfg_src_ext(cfg_src_ext), .cfg_div(cfg_div), .cfg_fs64(cfg_fs64),
    .bclk_en(bclk_en), .bclk(bclk), .lrclk(lrclk), .frame_en(frame_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference tick generator: one tick every gap cycles.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    pll_tick <= (cyc % pll_gap) == 0;
    ext_tick <= (cyc % ext_gap) == 0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit src, input int dv, input bit f64);
    cfg_src_ext = src; cfg_div = 7'(dv); cfg_fs64 = f64;
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(output longint t);
    do @(negedge clk); while (!bclk_en);
    t = cyc;
  endtask

  task automatic wait_frame(output longint t);
    do @(negedge clk); while (!frame_en);
    t = cyc;
  endtask

  task automatic bit_interval(output longint iv);
    longint a, b;
    wait_pulse(a); wait_pulse(a); wait_pulse(b);
    iv = b - a;
  endtask

  task automatic test_reset();
    do_reset(1'b1, 4, 1'b0);
    @(negedge clk); rst = 1'b1; @(negedge clk);
    check(!bclk && !lrclk && !bclk_en && !frame_en, "R1 in reset",
          {bclk, lrclk, bclk_en, frame_en}, 0);
    rst = 1'b0; @(negedge clk);
    check(!bclk && !lrclk && !bclk_en && !frame_en, "R1 after reset",
          {bclk, lrclk, bclk_en, frame_en}, 0);
  endtask

  task automatic test_ext(input int dv, input int gap);
    longint iv;
    ext_gap = gap;
    do_reset(1'b1, dv, 1'b0);
    bit_interval(iv);
    check(iv == longint'(dv * gap), "R2 ext period", iv, dv * gap);
  endtask

  task automatic test_pll(input int dv, input int gap);
    longint iv;
    pll_gap = gap;
    do_reset(1'b0, dv, 1'b0);
    bit_interval(iv);
    check(iv == longint'(2 * dv * gap), "R3 pll period", iv, 2 * dv * gap);
  endtask

  task automatic test_odd(input int dv);
    longint tr, tf, t0;
    ext_gap = 1;
    do_reset(1'b1, dv, 1'b0);
    wait_pulse(t0);
    do @(negedge clk); while (!bclk);
    tr = cyc;
    do @(negedge clk); while (bclk);
    tf = cyc;
    check(tf - tr == longint'(dv / 2), "R4 high phase", tf - tr, dv / 2);
    check(tr - t0 == longint'(dv - dv / 2), "R4 low phase", tr - t0, dv - dv / 2);
  endtask

  task automatic test_div1(input int dv);
    longint iv;
    bit seen_high = 0;
    ext_gap = 3;
    do_reset(1'b1, dv, 1'b0);
    bit_interval(iv);
    check(iv == 3, "R5 div0/1 period", iv, 3);
    repeat (60) begin
      @(negedge clk);
      if (bclk) seen_high = 1;
    end
    check(!seen_high, "R5 bclk stays low", seen_high, 0);
  endtask

  task automatic test_frame(input bit f64, input string req);
    longint t0, t1, t2;
    int nbits = f64 ? 64 : 128;
    bit prev_lr;
    int bad_moves = 0;
    int pulses = 0;
    ext_gap = 1;
    do_reset(1'b1, 2, f64);
    wait_frame(t0);
    prev_lr = lrclk;
    do begin
      @(negedge clk);
      if (lrclk != prev_lr && !bclk_en) bad_moves++;
      if (lrclk && !prev_lr) t1 = cyc;
      prev_lr = lrclk;
      if (bclk_en) pulses++;
    end while (!frame_en);
    t2 = cyc;
    check(t1 - t0 == longint'(nbits), {req, " low half"}, t1 - t0, nbits);
    check(t2 - t1 == longint'(nbits), {req, " high half"}, t2 - t1, nbits);
    check(pulses == nbits, {req, " bits per frame (R10)"}, pulses, nbits);
    check(bad_moves == 0, "R8 lrclk moves off bclk_en", bad_moves, 0);
    check(!lrclk, "R10 lrclk low at frame_en", lrclk, 0);
  endtask

  task automatic test_reload();
    longint iv, t0, t1, ta, tb;
    ext_gap = 1;
    do_reset(1'b1, 2, 1'b1);
    wait_frame(t0);
    repeat (5) wait_pulse(t1);
    cfg_div = 7'd4; cfg_fs64 = 1'b0;
    wait_pulse(ta); wait_pulse(tb);
    check(tb - ta == 2, "R9 divisor held mid-frame", tb - ta, 2);
    wait_frame(t1);
    check(t1 - t0 == 128, "R9 old frame length kept", t1 - t0, 128);
    wait_pulse(tb);
    check(tb - t1 == 4, "R9 new divisor after wrap", tb - t1, 4);
    wait_frame(t0);
    check(t0 - t1 == 512, "R9 new mode after wrap", t0 - t1, 512);
    cfg_src_ext = 1'b0; pll_gap = 2;
    bit_interval(iv);
    check(iv == 4, "R9 source held mid-frame", iv, 4);
    wait_frame(t0);
    bit_interval(iv);
    check(iv == 16, "R9 source switched after wrap", iv, 16);
  endtask

  initial begin
    test_reset();
    test_ext(8, 1);
    test_ext(4, 3);
    test_pll(6, 1);
    test_pll(9, 2);
    test_odd(9);
    test_odd(7);
    test_div1(0);
    test_div1(1);
    test_frame(1'b0, "R6");
    test_frame(1'b1, "R7");
    test_reload();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule